// File: doc/BRIEF.md
# Wait-State and Ready Sequencer

This block sets the length of every external bus cycle. A requester presents a cycle request together with a chip-select region identifier. The block looks up that region's programmed wait-state code and its "external ready required" flag. It then walks the cycle through the T-states T1, T2 and T3, inserts wait states (Tw), and ends with T4. The block behaves the same whatever unit started the cycle, whether the CPU or a DMA engine. The current T-state is reported on an output, and a one-clock done pulse marks T4.

Two ready inputs exist. One is asynchronous and passes through two register stages. The other is synchronous and passes through one stage. The two synchronized values are ORed into a single internal bus-ready. When a region requires ready, the programmed wait states always run to completion. Ready is examined at one sample point: the first Tw, or T3 for a zero-wait region. If ready is missing at that point, the cycle stretches until ready is seen, and one further Tw follows before T4.

Region 0 is the on-chip memory region. It has zero wait states and never waits for ready. Regions 1 to 5 hold a 2-bit wait code. Regions 6 to 9 hold a 3-bit wait code whose upper half selects longer waits.

Top module: `bus_wait_seq`

## Requirements
- R1: After reset, `tstate_o` is 0 (idle) and `done_o` is 0. Every region other than region 0 then holds wait code 3 with ready required.
- R2: `tstate_o` encodes idle=0, T1=1, T2=2, T3=3, Tw=4 and T4=5. A cycle with zero wait states is T1, T2, T3, T4, which is 4 clocks. Each wait state adds one Tw clock between T3 and T4.
- R3: Regions 1 to 5 use the two low bits of the written code, giving 0 to 3 wait states. Bit 2 of a write to these regions is ignored, so code 7 gives 3 wait states.
- R4: Regions 6 to 9 decode the 3-bit code as follows: 0 to 3 give 0 to 3 wait states, 4 gives 5, 5 gives 7, 6 gives 9 and 7 gives 15.
- R5: For a region with ready not required, the cycle length depends only on the wait code. Neither ready input changes it.
- R6: Region 0, and any identifier of 10 or above, gives a 4-clock cycle with ready ignored. Configuration writes to region 0 have no effect.
- R7: When ready is required and internal ready is high at the sample point, the cycle has exactly the programmed number of wait states. The sample point is the first Tw, or T3 when the code gives zero wait states. For example, 2 wait states give a 6-clock cycle.
- R8: When ready is required but low at the sample point, let k be the Tw (counted from 1) in which internal ready is first high. The cycle then has the larger of N and k+1 wait states, where N is the programmed count.
- R9: `srdy_i` reaches internal ready one clock after it is sampled, and `ardy_i` two clocks after. Either input alone makes internal ready high.
- R10: `done_o` is high for exactly one clock, and that clock is the T4 state.
- R11: A request is accepted only from idle or during T4. A request held during T1 to Tw is ignored. A request held through T4 starts T1 on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_region_i | input | 4 | Region written |
| cfg_code_i | input | 3 | Wait-state code written |
| cfg_rdy_req_i | input | 1 | Written value of the "ready required" flag |
| req_i | input | 1 | Bus cycle request |
| req_region_i | input | 4 | Region identifier of the requested cycle |
| ardy_i | input | 1 | Asynchronous external ready |
| srdy_i | input | 1 | Synchronous external ready |
| tstate_o | output | 3 | Current T-state (encoding in R2) |
| done_o | output | 1 | One-clock pulse in T4 |

## Verification
The hardest case to reach is a ready that arrives after the sample point at a chosen Tw index. The index depends on which input carries ready, because the two inputs have different synchronizer depths. The stimulus therefore counts falling edges from the first T1 and raises `srdy_i` or `ardy_i` at a computed edge. This lands the first internal-ready clock exactly at T3, at Tw1, or at a later Tw. Comparing the two inputs on a zero-wait region with ready required separates the one-stage path from the two-stage path by two whole wait states.

// File: rtl/bws_pkg.sv
package bws_pkg;

  localparam int MAX_WAIT = 15;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int CODE_W   = 3;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  function automatic logic [CNT_W-1:0] decode_wide(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] w;
    case (code)
      3'd4:    w = CNT_W'(5);
      3'd5:    w = CNT_W'(7);
      3'd6:    w = CNT_W'(9);
      3'd7:    w = CNT_W'(MAX_WAIT);
      default: w = CNT_W'(code);
    endcase
    return w;
  endfunction

  function automatic logic [CNT_W-1:0] decode_narrow(input logic [1:0] code);
    return CNT_W'(code);
  endfunction

endpackage

// File: rtl/bws_ready_sync.sv
module bws_ready_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ardy_i,
  input  logic srdy_i,
  output logic rdy_o
);

  logic a_s1_q, a_s2_q, s_s1_q;
  logic a_s1_d, a_s2_d, s_s1_d;

  always_comb begin
    a_s1_d = ardy_i;
    a_s2_d = a_s1_q;
    s_s1_d = srdy_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_s1_q <= 1'b0;
      a_s2_q <= 1'b0;
      s_s1_q <= 1'b0;
    end else begin
      a_s1_q <= a_s1_d;
      a_s2_q <= a_s2_d;
      s_s1_q <= s_s1_d;
    end
  end

  assign rdy_o = a_s2_q | s_s1_q;

  AST_SRDY_ONE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srdy_i |=> rdy_o); // R9
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srdy_i && !ardy_i && !$past(ardy_i)) |=> !rdy_o); // R9

endmodule

// File: rtl/bws_region_cfg.sv
module bws_region_cfg
  import bws_pkg::*;
#(
  parameter int NUM_REGIONS    = 10,
  parameter int NARROW_REGIONS = 6,
  parameter int RID_W          = $clog2(NUM_REGIONS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [RID_W-1:0]    cfg_region_i,
  input  logic [CODE_W-1:0]   cfg_code_i,
  input  logic                cfg_rdy_req_i,
  input  logic [RID_W-1:0]    lk_region_i,
  output logic [CNT_W-1:0]    lk_wait_o,
  output logic                lk_rdy_req_o
);

  localparam logic [CODE_W-1:0] RESET_CODE = CODE_W'(3);

  logic [CNT_W-1:0] wait_arr [NUM_REGIONS];
  logic             rreq_arr [NUM_REGIONS];

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    if (r == 0) begin : g_internal
      assign wait_arr[r] = '0;
      assign rreq_arr[r] = 1'b0;
    end else begin : g_ext
      logic              wr_en;
      logic              rreq_q, rreq_d;
      assign wr_en = cfg_we_i && (cfg_region_i == RID_W'(r));

      always_comb begin
        rreq_d = rreq_q;
        if (wr_en) rreq_d = cfg_rdy_req_i;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rreq_q <= 1'b1;
        else         rreq_q <= rreq_d;
      end
      assign rreq_arr[r] = rreq_q;

      if (r < NARROW_REGIONS) begin : g_narrow
        logic [1:0] code_q, code_d;
        always_comb begin
          code_d = code_q;
          if (wr_en) code_d = cfg_code_i[1:0];
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) code_q <= RESET_CODE[1:0];
          else         code_q <= code_d;
        end
        assign wait_arr[r] = decode_narrow(code_q);
      end else begin : g_wide
        logic [CODE_W-1:0] code_q, code_d;
        always_comb begin
          code_d = code_q;
          if (wr_en) code_d = cfg_code_i;
        end
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) code_q <= RESET_CODE;
          else         code_q <= code_d;
        end
        assign wait_arr[r] = decode_wide(code_q);
      end
    end
  end

  always_comb begin
    lk_wait_o    = '0;
    lk_rdy_req_o = 1'b0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (lk_region_i == RID_W'(r)) begin
        lk_wait_o    = wait_arr[r];
        lk_rdy_req_o = rreq_arr[r];
      end
    end
  end

  AST_INTERNAL_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_region_i == '0) |-> (lk_wait_o == '0 && !lk_rdy_req_o)); // R6

endmodule

// File: rtl/bws_sequencer.sv
module bws_sequencer
  import bws_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] lk_wait_i,
  input  logic             lk_rdy_req_i,
  input  logic             rdy_i,
  output tstate_e          tstate_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] IDX_MAX = CNT_W'(MAX_WAIT);
  localparam logic [CNT_W-1:0] IDX_ONE = CNT_W'(1);

  tstate_e          state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] nwait_q, nwait_d;
  logic             rreq_q, rreq_d;
  logic             late_q, late_d;
  logic             seen_q, seen_d;
  logic             accept;
  logic             late_now;

  always_comb begin
    accept   = req_i && (state_q == TS_IDLE || state_q == TS_T4);
    late_now = late_q;
    if (state_q == TS_TW && idx_q == IDX_ONE && nwait_q != '0)
      late_now = rreq_q && !rdy_i;

    state_d = state_q;
    idx_d   = idx_q;
    nwait_d = nwait_q;
    rreq_d  = rreq_q;
    late_d  = late_q;
    seen_d  = seen_q;

    case (state_q)
      TS_IDLE, TS_T4: begin
        if (accept) begin
          state_d = TS_T1;
          nwait_d = lk_wait_i;
          rreq_d  = lk_rdy_req_i;
          idx_d   = '0;
          late_d  = 1'b0;
          seen_d  = 1'b0;
        end else begin
          state_d = TS_IDLE;
        end
      end
      TS_T1: state_d = TS_T2;
      TS_T2: state_d = TS_T3;
      TS_T3: begin
        if (nwait_q != '0) begin
          state_d = TS_TW;
          idx_d   = IDX_ONE;
        end else if (rreq_q && !rdy_i) begin
          state_d = TS_TW;
          idx_d   = IDX_ONE;
          late_d  = 1'b1;
        end else begin
          state_d = TS_T4;
        end
      end
      TS_TW: begin
        late_d = late_now;
        seen_d = seen_q | rdy_i;
        if (idx_q >= nwait_q && (!rreq_q || !late_now || seen_q))
          state_d = TS_T4;
        else if (idx_q != IDX_MAX)
          idx_d = idx_q + IDX_ONE;
      end
      default: state_d = TS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      idx_q   <= '0;
      nwait_q <= '0;
      rreq_q  <= 1'b0;
      late_q  <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      nwait_q <= nwait_d;
      rreq_q  <= rreq_d;
      late_q  <= late_d;
      seen_q  <= seen_d;
    end
  end

  assign tstate_o = state_q;
  assign done_o   = (state_q == TS_T4);

  AST_T1_THEN_T2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T1) |=> (state_q == TS_T2)); // R2
  AST_T2_THEN_T3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T2) |=> (state_q == TS_T3)); // R2
  AST_ZERO_WAIT_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T3 && nwait_q == '0 && !rreq_q) |=> (state_q == TS_T4)); // R2
  AST_WAITS_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_TW && idx_q < nwait_q) |=> (state_q == TS_TW)); // R7
  AST_BUSY_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TS_T1 || state_q == TS_T2 || state_q == TS_T3 || state_q == TS_TW)
      |=> (state_q != TS_T1)); // R11
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10

endmodule

// File: rtl/bus_wait_seq.sv
module bus_wait_seq
  import bws_pkg::*;
#(
  parameter int NUM_REGIONS    = 10,
  parameter int NARROW_REGIONS = 6,
  parameter int RID_W          = $clog2(NUM_REGIONS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [RID_W-1:0]   cfg_region_i,
  input  logic [CODE_W-1:0]  cfg_code_i,
  input  logic               cfg_rdy_req_i,
  input  logic               req_i,
  input  logic [RID_W-1:0]   req_region_i,
  input  logic               ardy_i,
  input  logic               srdy_i,
  output logic [2:0]         tstate_o,
  output logic               done_o
);

  logic rst_s1_q, rst_s2_q;
  logic rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_n = rst_s2_q;

  logic [CNT_W-1:0] lk_wait;
  logic             lk_rreq;
  logic             bus_rdy;
  tstate_e          tstate;

  bws_region_cfg #(
    .NUM_REGIONS    (NUM_REGIONS),
    .NARROW_REGIONS (NARROW_REGIONS),
    .RID_W          (RID_W)
  ) u_cfg (
    .clk_i         (clk_i),
    .rst_ni        (rst_n),
    .cfg_we_i      (cfg_we_i),
    .cfg_region_i  (cfg_region_i),
    .cfg_code_i    (cfg_code_i),
    .cfg_rdy_req_i (cfg_rdy_req_i),
    .lk_region_i   (req_region_i),
    .lk_wait_o     (lk_wait),
    .lk_rdy_req_o  (lk_rreq)
  );

  bws_ready_sync u_rdy (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .ardy_i (ardy_i),
    .srdy_i (srdy_i),
    .rdy_o  (bus_rdy)
  );

  bws_sequencer u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .req_i        (req_i),
    .lk_wait_i    (lk_wait),
    .lk_rdy_req_i (lk_rreq),
    .rdy_i        (bus_rdy),
    .tstate_o     (tstate),
    .done_o       (done_o)
  );

  assign tstate_o = tstate;

endmodule

// File: tb/bus_wait_seq_tb.sv
module bus_wait_seq_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_we_i;
  logic [3:0] cfg_region_i;
  logic [2:0] cfg_code_i;
  logic       cfg_rdy_req_i;
  logic       req_i;
  logic [3:0] req_region_i;
  logic       ardy_i;
  logic       srdy_i;
  logic [2:0] tstate_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;
  bit mon_on = 0;

  int    exp_len_q [$];
  string exp_tag_q [$];
  int    cyc_len;
  bit    prev_done;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  bus_wait_seq u_dut (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cfg_we_i      (cfg_we_i),
    .cfg_region_i  (cfg_region_i),
    .cfg_code_i    (cfg_code_i),
    .cfg_rdy_req_i (cfg_rdy_req_i),
    .req_i         (req_i),
    .req_region_i  (req_region_i),
    .ardy_i        (ardy_i),
    .srdy_i        (srdy_i),
    .tstate_o      (tstate_o),
    .done_o        (done_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected wait states from the requirements; src 0 none, 1 srdy, 2 ardy
  function automatic int exp_waits(int n, bit rreq, int src, int j);
    int k, s;
    if (!rreq) return n;
    if (j < 0) k = -5;
    else if (src == 1) k = j - 1;
    else k = j;
    s = (n == 0) ? 0 : 1;
    if (k <= s) return n;
    return (n > k + 1) ? n : k + 1;
  endfunction

  // Monitor: measures cycle length from T1 to T4 and compares with scoreboard
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (tstate_o == 3'd1) cyc_len = 1;
      else if (tstate_o != 3'd0) cyc_len++;
      if (done_o) begin
        check(tstate_o == 3'd5, "R10 done outside T4", tstate_o, 5);
        check(!prev_done, "R10 done longer than one clock", 2, 1);
        if (exp_len_q.size() == 0) begin
          check(1'b0, "R11 unexpected cycle", cyc_len, 0);
        end else begin
          string t;
          int e;
          e = exp_len_q.pop_front();
          t = exp_tag_q.pop_front();
          check(cyc_len == e, t, cyc_len, e);
        end
      end
      prev_done = done_o;
    end
  end

  task automatic cfg_write(input int region, input int code, input bit rreq);
    @(negedge clk_i);
    cfg_we_i      = 1'b1;
    cfg_region_i  = 4'(region);
    cfg_code_i    = 3'(code);
    cfg_rdy_req_i = rreq;
    @(negedge clk_i);
    cfg_we_i      = 1'b0;
  endtask

  // Driver: one cycle; ready raised at falling edge j counted from the first T1
  task automatic run_cycle(input int region, input int src, input int j,
                           input int waits, input string tag);
    exp_len_q.push_back(4 + waits);
    exp_tag_q.push_back(tag);
    @(negedge clk_i);
    if (j < 0) begin
      if (src == 1) srdy_i = 1'b1;
      if (src == 2) ardy_i = 1'b1;
      repeat (3) @(negedge clk_i);
    end
    req_region_i = 4'(region);
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    for (int n = 0; n < 200; n++) begin
      if (n == j) begin
        if (src == 1) srdy_i = 1'b1;
        if (src == 2) ardy_i = 1'b1;
      end
      if (done_o) break;
      @(negedge clk_i);
    end
    srdy_i = 1'b0;
    ardy_i = 1'b0;
    @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    cfg_we_i = 1'b0; cfg_region_i = '0; cfg_code_i = '0; cfg_rdy_req_i = 1'b0;
    req_i = 1'b0; req_region_i = '0; ardy_i = 1'b0; srdy_i = 1'b0;
    cyc_len = 0; prev_done = 0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check(tstate_o == 3'd0, "R1 reset tstate", tstate_o, 0);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    mon_on = 1;

    // R1 defaults: code 3 with ready required
    run_cycle(1, 1, -1, 3, "R1 default narrow region");
    run_cycle(8, 1, -1, 3, "R1 default wide region");

    // R3 narrow codes
    cfg_write(2, 0, 0);
    run_cycle(2, 0, 0, 0, "R2 R3 zero wait cycle");
    cfg_write(2, 2, 0);
    run_cycle(2, 0, 0, 2, "R3 narrow code 2");
    cfg_write(2, 7, 0);
    run_cycle(2, 0, 0, 3, "R3 narrow bit2 ignored");

    // R4 wide codes
    cfg_write(6, 1, 0);
    run_cycle(6, 0, 0, 1, "R4 wide code 1");
    cfg_write(6, 4, 0);
    run_cycle(6, 0, 0, 5, "R4 wide code 4");
    cfg_write(6, 5, 0);
    run_cycle(6, 0, 0, 7, "R4 wide code 5");
    cfg_write(6, 6, 0);
    run_cycle(6, 0, 0, 9, "R4 wide code 6");
    cfg_write(6, 7, 0);
    run_cycle(6, 0, 0, 15, "R4 wide code 7");

    // R5 ready ignored
    cfg_write(6, 2, 0);
    run_cycle(6, 0, 0, 2, "R5 ready low ignored");
    run_cycle(6, 1, 5, 2, "R5 late srdy ignored");
    run_cycle(6, 2, -1, 2, "R5 early ardy ignored");

    // R6 internal region
    cfg_write(0, 7, 1);
    run_cycle(0, 0, 0, 0, "R6 internal region zero wait");
    run_cycle(12, 0, 0, 0, "R6 out of range id");

    // R7 ready at the sample point
    cfg_write(3, 2, 1);
    run_cycle(3, 1, -1, exp_waits(2, 1, 1, -1), "R7 ready early");
    run_cycle(3, 1, 2, exp_waits(2, 1, 1, 2), "R7 ready at first Tw");

    // R8 late ready
    run_cycle(3, 1, 3, exp_waits(2, 1, 1, 3), "R8 ready at Tw2");
    run_cycle(3, 1, 6, exp_waits(2, 1, 1, 6), "R8 ready at Tw5");
    cfg_write(7, 5, 1);
    run_cycle(7, 1, 4, exp_waits(7, 1, 1, 4), "R8 late within programmed");
    cfg_write(4, 0, 1);
    run_cycle(4, 1, 3, exp_waits(0, 1, 1, 3), "R8 zero wait late ready");

    // R9 synchronizer depth
    run_cycle(4, 1, 1, exp_waits(0, 1, 1, 1), "R9 srdy one stage");
    run_cycle(4, 2, 1, exp_waits(0, 1, 2, 1), "R9 ardy two stages");
    run_cycle(3, 2, 2, exp_waits(2, 1, 2, 2), "R9 ardy late");

    // R11 back-to-back with request held through the whole first cycle
    cfg_write(5, 1, 0);
    exp_len_q.push_back(5); exp_tag_q.push_back("R11 first held cycle");
    exp_len_q.push_back(5); exp_tag_q.push_back("R11 back to back cycle");
    @(negedge clk_i);
    req_region_i = 4'd5;
    req_i = 1'b1;
    begin
      int t1s = 0;
      for (int n = 0; n < 50 && t1s < 2; n++) begin
        @(negedge clk_i);
        if (tstate_o == 3'd1) t1s++;
      end
    end
    req_i = 1'b0;
    for (int n = 0; n < 50 && !done_o; n++) @(negedge clk_i);
    @(negedge clk_i);
    check(tstate_o == 3'd0, "R11 idle after request dropped", tstate_o, 0);

    repeat (5) @(negedge clk_i);
    check(exp_len_q.size() == 0, "R11 scoreboard drained", exp_len_q.size(), 0);
    finish_run();
  end

endmodule